// File: doc/BRIEF.md
# Triggered DMA Request Underrun Detector

This block sits beside one converter channel. It turns each external conversion trigger into a single DMA request and holds that request until the DMA controller acknowledges it. Requests never queue. If a new trigger arrives while a request is still outstanding, the block does not issue a second request. Instead it raises a sticky underrun flag and locks the channel out of DMA service. It also asserts a hold signal, which tells the data path to keep converting the data it already has.

Software clears the flag by writing one to its bit through a small register write port. Clearing the flag alone does not restore service. The channel must also see its DMA enable low for at least one cycle while the flag is clear. After that, setting the enable again lets triggers produce requests. An interrupt level reports the flag whenever the channel's underrun interrupt enable is set.

Top module: `dma_trig_udr`

## Requirements
- R1: After reset, the request, flag, interrupt and hold outputs are all 0.
- R2: When a trigger is sampled with the DMA enable at 1, no request outstanding and the channel not locked, the request output is 1 from the next clock onward.
- R3: When the acknowledge is sampled at 1 with no trigger in the same cycle, the request output is 0 after that clock.
- R4: A trigger and an acknowledge sampled in the same cycle on an outstanding request leave the request at 1 and do not set the flag.
- R5: A trigger sampled while a request is outstanding and unacknowledged, with the enable at 1, sets the flag and the hold output and drops the request, all on the next clock.
- R6: While the hold output is 1, triggers produce no request. This holds even after the flag has been cleared, as long as the enable has stayed at 1.
- R7: A write with wr_data_i bit UDR_BIT (default 13) at 1 clears the flag on the next clock. A write with that bit at 0, whatever the other bits hold, leaves the flag unchanged.
- R8: If an underrun and a clearing write happen in the same cycle, the flag ends up set.
- R9: The interrupt output is a level that is 1 exactly when the flag is 1 and the interrupt enable input is 1. Dropping the enable clears the interrupt but leaves the flag as it was.
- R10: The hold output returns to 0 one clock after a cycle in which the DMA enable is sampled at 0 while the flag is 0. From then on, triggers with the enable at 1 produce requests again.
- R11: A cycle with the DMA enable sampled at 0 leaves the request at 0 after that clock. Triggers in such a cycle neither issue a request nor set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Conversion trigger pulse |
| ack_i | input | 1 | DMA acknowledge |
| dma_en_i | input | 1 | DMA service enable for the channel |
| udr_ie_i | input | 1 | Underrun interrupt enable |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | DATA_W | Status write data; bit UDR_BIT is the clear bit |
| dma_req_o | output | 1 | Outstanding DMA request |
| udr_flag_o | output | 1 | Sticky underrun flag |
| irq_o | output | 1 | Underrun interrupt level |
| hold_o | output | 1 | Keep converting the last held data |

## Verification
The handshake is tried with three trigger patterns. The first waits for the acknowledge before the next trigger. The second lands the trigger in the same cycle as the acknowledge. The third repeats the trigger with no acknowledge in between. Together these separate a clean handoff from an underrun. The recovery path is driven in both orders:
- the flag is cleared before the enable drops;
- the enable drops before the flag is cleared.

This shows that the lock depends on both conditions. Writes with the clear bit at 0 but every other bit set check that the clear decodes only its own bit. An underrun that coincides with a clearing write checks which one takes priority.

// File: rtl/dma_udr_pkg.sv
package dma_udr_pkg;

    typedef struct packed {
        logic req;
    } req_state_t;

    typedef struct packed {
        logic flag;
        logic lock;
    } flag_state_t;

endpackage

// File: rtl/dma_udr_req.sv
module dma_udr_req
    import dma_udr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic ack_i,
    input  logic en_i,
    input  logic lock_i,
    output logic req_o,
    output logic udr_evt_o
);

    req_state_t st_d, st_q;
    logic       live;
    logic       accept;

    always_comb begin
        st_d      = st_q;
        live      = trig_i && en_i && !lock_i;
        accept    = live && (!st_q.req || ack_i);
        udr_evt_o = live && st_q.req && !ack_i;
        if (accept) begin
            st_d.req = 1'b1;
        end else if (ack_i || udr_evt_o || !en_i || lock_i) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;

    p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.req) |-> $past(trig_i) && $past(en_i));

    p_ack_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && ack_i && !trig_i) |=> !st_q.req);

    p_handoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && ack_i && trig_i && en_i && !lock_i) |=> st_q.req);

endmodule

// File: rtl/dma_udr_flag.sv
module dma_udr_flag
    import dma_udr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic udr_evt_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic lock_o
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // an underrun in the same cycle as a clearing write wins
        if (udr_evt_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
        if (udr_evt_i) begin
            st_d.lock = 1'b1;
        end else if (!en_i && !st_q.flag) begin
            st_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign lock_o = st_q.lock;

    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && clr_i && !udr_evt_i) |=> !st_q.flag);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr_i) |=> st_q.flag);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        udr_evt_i |=> st_q.flag && st_q.lock);

    p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && st_q.flag) |=> st_q.lock);

endmodule

// File: rtl/dma_trig_udr.sv
module dma_trig_udr #(
    parameter int DATA_W  = 32,
    parameter int UDR_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              ack_i,
    input  logic              dma_en_i,
    input  logic              udr_ie_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              dma_req_o,
    output logic              udr_flag_o,
    output logic              irq_o,
    output logic              hold_o
);

    localparam int BIT_IDX = (UDR_BIT < DATA_W) ? UDR_BIT : DATA_W - 1;

    logic udr_evt;
    logic clr;
    logic lock;

    assign clr = wr_en_i && wr_data_i[BIT_IDX];

    dma_udr_req u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_i),
        .ack_i     (ack_i),
        .en_i      (dma_en_i),
        .lock_i    (lock),
        .req_o     (dma_req_o),
        .udr_evt_o (udr_evt)
    );

    dma_udr_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .udr_evt_i (udr_evt),
        .clr_i     (clr),
        .en_i      (dma_en_i),
        .flag_o    (udr_flag_o),
        .lock_o    (lock)
    );

    assign irq_o  = udr_flag_o && udr_ie_i;
    assign hold_o = lock;

    p_underrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && dma_en_i && dma_req_o && !ack_i && !hold_o)
            |=> udr_flag_o && hold_o && !dma_req_o);

    p_locked_noreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> !dma_req_o);

    p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en_i |=> !dma_req_o);

    p_disabled_noflag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en_i && !udr_flag_o) |=> !udr_flag_o);

endmodule

// File: tb/sim_dma_trig_udr.sv
module sim_dma_trig_udr;

    localparam int DATA_W  = 32;
    localparam int UDR_BIT = 13;
    localparam int NVEC    = 25;

    // {trig, ack, en, ie, wr, clr_bit, exp_req, exp_flag, exp_irq, exp_hold}
    localparam logic [9:0] VEC [0:NVEC-1] = '{
        10'b001000_0000,
        10'b101000_1000,
        10'b001000_1000,
        10'b011000_0000,
        10'b101000_1000,
        10'b111000_1000,
        10'b011000_0000,
        10'b101100_1000,
        10'b101100_0111,
        10'b101100_0111,
        10'b001000_0101,
        10'b001110_0111,
        10'b001111_0001,
        10'b101100_0001,
        10'b000100_0000,
        10'b100100_0000,
        10'b101100_1000,
        10'b000000_0000,
        10'b100000_0000,
        10'b101000_1000,
        10'b101011_0101,
        10'b001000_0101,
        10'b000000_0101,
        10'b000011_0001,
        10'b000000_0000
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_i = 1'b0;
    logic              ack_i = 1'b0;
    logic              dma_en_i = 1'b0;
    logic              udr_ie_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic              dma_req_o, udr_flag_o, irq_o, hold_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_trig_udr #(.DATA_W(DATA_W), .UDR_BIT(UDR_BIT)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .ack_i(ack_i),
        .dma_en_i(dma_en_i), .udr_ie_i(udr_ie_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .dma_req_o(dma_req_o), .udr_flag_o(udr_flag_o),
        .irq_o(irq_o), .hold_o(hold_o)
    );

    function automatic string tag_of(int i);
        case (i)
            1, 2, 16, 19: return "R2";
            3, 6:         return "R3";
            5:            return "R4";
            8:            return "R5";
            9, 13:        return "R6";
            10:           return "R9";
            11, 12:       return "R7";
            14, 22, 23, 24: return "R10";
            15, 17, 18:   return "R11";
            20:           return "R8";
            default:      return "R2";
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] exp);
        logic [3:0] act;
        act = {dma_req_o, udr_flag_o, irq_o, hold_o};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s req/flag/irq/hold actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(logic t, logic a, logic e, logic ie, logic w,
                         logic [DATA_W-1:0] d);
        trig_i = t; ack_i = a; dma_en_i = e; udr_ie_i = ie;
        wr_en_i = w; wr_data_i = d;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [DATA_W-1:0] wd;
        repeat (2) @(negedge clk);
        check("R1", 4'b0000);  // reset state
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 4'b0000);

        for (int i = 0; i < NVEC; i++) begin
            wd = '0;
            wd[UDR_BIT] = VEC[i][4];
            drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], wd);
            @(negedge clk);
            check(tag_of(i), VEC[i][3:0]);
        end

        // R7: every bit except the clear bit set must not clear the flag
        drive(1, 0, 1, 1, 0, '0); @(negedge clk);  // issue request
        drive(1, 0, 1, 1, 0, '0); @(negedge clk);  // underrun
        check("R5", 4'b0111);
        wd = '1;
        wd[UDR_BIT] = 1'b0;
        drive(0, 0, 1, 1, 1, wd); @(negedge clk);
        check("R7", 4'b0111);

        // R11: trigger with enable low does not set flag on a cleared channel
        wd = '0;
        wd[UDR_BIT] = 1'b1;
        drive(0, 0, 0, 1, 1, wd); @(negedge clk);  // clear, lock still set this edge
        check("R7", 4'b0001);
        drive(1, 0, 0, 1, 0, '0); @(negedge clk);
        check("R11", 4'b0000);

        // R4: repeated back-to-back handoffs never underrun
        drive(1, 0, 1, 0, 0, '0); @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            drive(1, 1, 1, 0, 0, '0); @(negedge clk);
            check("R4", 4'b1000);
        end

        // R1: mid-run reset clears everything
        drive(1, 0, 1, 1, 0, '0); @(negedge clk);
        check("R5", 4'b0111);
        rst_n = 1'b0;
        #1;
        check("R1", 4'b0000);
        drive(0, 0, 0, 0, 0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 4'b0000);

        done = 1'b1;
        finish_run();
    end

endmodule